// File: doc/BRIEF.md
# Dual-Port RAM with Resettable Output Stages

A synthesizable memory with two independent access ports, A and B. Each port can read or write any word on its own; writes are split into byte lanes so that a port can update part of a word and leave the other lanes alone. Reads are read-first: a port that writes a word in a cycle sees that word's previous contents on its read path.

Each port's read path has two stages. The first is a data latch that captures the addressed word on every enabled cycle. The second is an optional output register, chosen per port by a parameter, that adds one cycle of latency under its own clock enable. Each stage has its own synchronous reset input, which loads a per-port constant instead of memory data. A per-port parameter decides whether the register reset wins over the register clock enable or needs it. Both ports share one clock. A collision detector flags cycles in which both ports touch the same word and at least one writes. A mode parameter chooses what happens then: flag only with state held, flag with read latches marked invalid, or no checking at all.

Top module: `tdp_ram_rso`

## Requirements
- R1: When a port is enabled and its write-enable bit i is set, lane i (bits 8i+7 down to 8i) of the addressed word takes the matching lane of that port's write data; lanes whose bit is clear keep their contents.
- R2: Reads are read-first: in a cycle where a port writes a word, its read latch captures the contents that word held before the write.
- R3: With the port enabled, the latch reset loads the port's reset constant into the latch whatever the output register setting; with the port enable low, the latch and its reset have no effect and the latch holds.
- R4: With the output register enabled, the read data shows the latch contents one cycle after the latch loads (clock enable high); with it bypassed, the read data is the latch contents in the cycle it loads.
- R5: The register reset loads the port's reset constant into the output register when that register is enabled, and has no effect on the read data when it is bypassed.
- R6: With reset-first priority the register reset acts whether or not the register clock enable is high; with enable-first priority it acts only when the clock enable is high; with the clock enable low and no effective reset the register holds.
- R7: The collision output is high for exactly the one cycle after a clock edge at which both ports were enabled on the same address with at least one write enable bit set, when the collision mode is not "none"; it is low otherwise.
- R8: In the warn-only collision mode, a collision blocks both ports' writes for that cycle and both read latches hold their previous values.
- R9: In the invalidate collision mode, a collision blocks both ports' writes for that cycle and both read latches load their port's reset constant.
- R10: While the active-low reset is sampled low, the latches and output registers load their port's reset constant and the collision output is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset of read stages and flag |
| a_en | input | 1 | Port A enable |
| a_we | input | LANES | Port A byte-lane write enables |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | LANES*LANE_W | Port A write data |
| a_regce | input | 1 | Port A output register clock enable |
| a_rst_latch | input | 1 | Port A latch reset |
| a_rst_reg | input | 1 | Port A output register reset |
| a_rdata | output | LANES*LANE_W | Port A read data |
| b_en | input | 1 | Port B enable |
| b_we | input | LANES | Port B byte-lane write enables |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | LANES*LANE_W | Port B write data |
| b_regce | input | 1 | Port B output register clock enable |
| b_rst_latch | input | 1 | Port B latch reset |
| b_rst_reg | input | 1 | Port B output register reset |
| b_rdata | output | LANES*LANE_W | Port B read data |
| collision | output | 1 | One-cycle collision flag |

## Verification
A wrong memory lane or a missed write block stays hidden until the word is read back, so the bench reads every written word through the other port and sees a bad lane one read latency later. A latch that loads at the wrong time shows on the read data at once on a bypassed port and one cycle later on a registered port, which is why each reset and hold case is sampled on both sides of that extra cycle. A wrong priority decision in the output register shows in the single cycle where the register reset is high and the clock enable low, and a wrong collision decision shows on the flag the cycle after the access and on the read data within two cycles.

// File: rtl/ram_pkg.sv
// Package ram_pkg
// Shared types for the dual-port RAM: the collision handling mode.
// Assumes nothing beyond SystemVerilog 2017.
package ram_pkg;

    // What the memory does when both ports hit one word and one writes.
    typedef enum logic [1:0] {
        COLL_NONE = 2'd0,   // no detection, writes proceed, B wins lane ties
        COLL_WARN = 2'd1,   // flag, block writes, latches hold
        COLL_ALL  = 2'd2    // flag, block writes, latches load reset constant
    } coll_mode_e;

endpackage

// File: rtl/ram_store.sv
// Module ram_store
// Word array with two byte-lane write ports and two asynchronous read
// taps. Reads see the contents before the write of the current edge,
// which gives read-first behaviour to the latches downstream.
// Assumes one shared clock; when both ports write one lane, B is applied
// last and wins. wr_block suppresses both writes for the cycle.
module ram_store #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_block,
    input  logic              a_en,
    input  logic [LANES-1:0]  a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              b_en,
    input  logic [LANES-1:0]  b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] a_q,
    output logic [DATA_W-1:0] b_q
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Apply lane writes of port A, then port B.
    always_ff @(posedge clk) begin : store_write
        if (a_en && !wr_block) begin
            for (int l = 0; l < LANES; l++) begin
                if (a_we[l]) mem[a_addr][l*LANE_W +: LANE_W] <= a_wdata[l*LANE_W +: LANE_W];
            end
        end
        if (b_en && !wr_block) begin
            for (int l = 0; l < LANES; l++) begin
                if (b_we[l]) mem[b_addr][l*LANE_W +: LANE_W] <= b_wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    // Present the currently addressed words.
    assign a_q = mem[a_addr];
    assign b_q = mem[b_addr];

endmodule

// File: rtl/ram_coll.sv
// Module ram_coll
// Detects both ports enabled on one address with any write enable set,
// and turns the hit into write blocking, latch hold or latch invalidate
// according to the mode. The flag is registered: high the cycle after.
// Assumes one shared clock for both ports.
module ram_coll #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter ram_pkg::coll_mode_e MODE = ram_pkg::COLL_WARN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic [LANES-1:0]  a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_en,
    input  logic [LANES-1:0]  b_we,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              wr_block,
    output logic              hold,
    output logic              inval,
    output logic              flag
);

    localparam bit CHECKED = (MODE != ram_pkg::COLL_NONE);

    logic hit;

    // Raw conflict on the current cycle's requests.
    always_comb begin : detect
        hit = a_en && b_en && (a_addr == b_addr) && ((|a_we) || (|b_we));
    end

    // Map the conflict onto the mode's actions.
    always_comb begin : actions
        wr_block = CHECKED && hit;
        hold     = (MODE == ram_pkg::COLL_WARN) && hit;
        inval    = (MODE == ram_pkg::COLL_ALL)  && hit;
    end

    // One-cycle registered flag.
    always_ff @(posedge clk) begin : flag_reg
        if (!rst_n) flag <= 1'b0;
        else        flag <= CHECKED && hit;
    end

endmodule

// File: rtl/ram_out_stage.sv
// Module ram_out_stage
// Read path of one port: a data latch loaded on enabled cycles, followed
// by an optional output register. Both stages reset synchronously to
// RST_VAL. RSTREG_FIRST picks whether the register reset overrides the
// register clock enable. Assumes mem_q is the pre-write word (read-first).
module ram_out_stage #(
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] RST_VAL = '0,
    parameter bit OUT_REG      = 1'b1,
    parameter bit RSTREG_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rst_latch,
    input  logic              rst_reg,
    input  logic              regce,
    input  logic              coll_hold,
    input  logic              coll_inval,
    input  logic [DATA_W-1:0] mem_q,
    output logic [DATA_W-1:0] latch_q,
    output logic [DATA_W-1:0] rdata
);

    // Data latch: reset, invalidate, hold on collision, else capture.
    always_ff @(posedge clk) begin : latch_stage
        if (!rst_n) begin
            latch_q <= RST_VAL;
        end else if (en) begin
            if (rst_latch || coll_inval) latch_q <= RST_VAL;
            else if (!coll_hold)         latch_q <= mem_q;
        end
    end

    generate
        if (OUT_REG) begin : g_reg
            logic [DATA_W-1:0] out_q;
            if (RSTREG_FIRST) begin : g_rst_first
                // Register: reset wins over clock enable.
                always_ff @(posedge clk) begin : reg_stage
                    if (!rst_n)       out_q <= RST_VAL;
                    else if (rst_reg) out_q <= RST_VAL;
                    else if (regce)   out_q <= latch_q;
                end
            end else begin : g_ce_first
                // Register: reset acts only under clock enable.
                always_ff @(posedge clk) begin : reg_stage
                    if (!rst_n) out_q <= RST_VAL;
                    else if (regce) out_q <= rst_reg ? RST_VAL : latch_q;
                end
            end
            assign rdata = out_q;
        end else begin : g_bypass
            logic unused_reg_ctl;
            assign unused_reg_ctl = rst_reg ^ regce;
            assign rdata = latch_q;
        end
    endgenerate

endmodule

// File: rtl/tdp_ram_rso.sv
// Module tdp_ram_rso
// Dual-port RAM with byte-lane writes, read-first latches, optional
// per-port output registers with their own resets and priority rule, and
// a collision flag. Both ports run on clk; rst_n clears only the read
// stages and the flag, never the memory contents.
module tdp_ram_rso #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter logic [LANES*LANE_W-1:0] A_RST_VAL = 'hDEAD_BEEF,
    parameter logic [LANES*LANE_W-1:0] B_RST_VAL = 'h0BAD_F00D,
    parameter bit A_OUT_REG      = 1'b1,
    parameter bit B_OUT_REG      = 1'b0,
    parameter bit A_RSTREG_FIRST = 1'b1,
    parameter bit B_RSTREG_FIRST = 1'b1,
    parameter ram_pkg::coll_mode_e COLL_MODE = ram_pkg::COLL_WARN
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    a_en,
    input  logic [LANES-1:0]        a_we,
    input  logic [ADDR_W-1:0]       a_addr,
    input  logic [LANES*LANE_W-1:0] a_wdata,
    input  logic                    a_regce,
    input  logic                    a_rst_latch,
    input  logic                    a_rst_reg,
    output logic [LANES*LANE_W-1:0] a_rdata,
    input  logic                    b_en,
    input  logic [LANES-1:0]        b_we,
    input  logic [ADDR_W-1:0]       b_addr,
    input  logic [LANES*LANE_W-1:0] b_wdata,
    input  logic                    b_regce,
    input  logic                    b_rst_latch,
    input  logic                    b_rst_reg,
    output logic [LANES*LANE_W-1:0] b_rdata,
    output logic                    collision
);

    localparam int DATA_W = LANES * LANE_W;

    logic              wr_block, coll_hold, coll_inval;
    logic [DATA_W-1:0] a_q, b_q, a_latch, b_latch;

    ram_coll #(.ADDR_W(ADDR_W), .LANES(LANES), .MODE(COLL_MODE)) coll_i (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
        .wr_block(wr_block), .hold(coll_hold), .inval(coll_inval),
        .flag(collision)
    );

    ram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) store_i (
        .clk(clk), .wr_block(wr_block),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .a_q(a_q), .b_q(b_q)
    );

    ram_out_stage #(.DATA_W(DATA_W), .RST_VAL(A_RST_VAL),
                    .OUT_REG(A_OUT_REG), .RSTREG_FIRST(A_RSTREG_FIRST)) out_a_i (
        .clk(clk), .rst_n(rst_n), .en(a_en), .rst_latch(a_rst_latch),
        .rst_reg(a_rst_reg), .regce(a_regce), .coll_hold(coll_hold),
        .coll_inval(coll_inval), .mem_q(a_q), .latch_q(a_latch), .rdata(a_rdata)
    );

    ram_out_stage #(.DATA_W(DATA_W), .RST_VAL(B_RST_VAL),
                    .OUT_REG(B_OUT_REG), .RSTREG_FIRST(B_RSTREG_FIRST)) out_b_i (
        .clk(clk), .rst_n(rst_n), .en(b_en), .rst_latch(b_rst_latch),
        .rst_reg(b_rst_reg), .regce(b_regce), .coll_hold(coll_hold),
        .coll_inval(coll_inval), .mem_q(b_q), .latch_q(b_latch), .rdata(b_rdata)
    );

endmodule

// File: rtl/tdp_ram_rso_chk.sv
// Module tdp_ram_rso_chk
// Property checker for tdp_ram_rso, attached by bind below. Observes the
// ports and the two read latches.
module tdp_ram_rso_chk #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] A_RST_VAL = '0,
    parameter logic [DATA_W-1:0] B_RST_VAL = '0,
    parameter bit A_OUT_REG      = 1'b1,
    parameter bit B_OUT_REG      = 1'b0,
    parameter bit A_RSTREG_FIRST = 1'b1,
    parameter bit B_RSTREG_FIRST = 1'b1,
    parameter ram_pkg::coll_mode_e COLL_MODE = ram_pkg::COLL_WARN
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_en,
    input logic [LANES-1:0]  a_we,
    input logic [ADDR_W-1:0] a_addr,
    input logic              a_regce,
    input logic              a_rst_latch,
    input logic              a_rst_reg,
    input logic [DATA_W-1:0] a_rdata,
    input logic [DATA_W-1:0] a_latch,
    input logic              b_en,
    input logic [LANES-1:0]  b_we,
    input logic [ADDR_W-1:0] b_addr,
    input logic              b_regce,
    input logic              b_rst_latch,
    input logic              b_rst_reg,
    input logic [DATA_W-1:0] b_rdata,
    input logic [DATA_W-1:0] b_latch,
    input logic              collision
);

    localparam bit CHECKED = (COLL_MODE != ram_pkg::COLL_NONE);
    localparam bit WARN    = (COLL_MODE == ram_pkg::COLL_WARN);
    localparam bit INVAL   = (COLL_MODE == ram_pkg::COLL_ALL);

    logic conflict;
    assign conflict = a_en && b_en && (a_addr == b_addr) && ((|a_we) || (|b_we));

    // R3: idle port keeps its latch; enabled latch reset loads the constant
    a_r3_a_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !a_en |=> $stable(a_latch));
    a_r3_b_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !b_en |=> $stable(b_latch));
    a_r3_a_rst: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_rst_latch) |=> (a_latch == A_RST_VAL));
    a_r3_b_rst: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en && b_rst_latch) |=> (b_latch == B_RST_VAL));

    // R4: registered read data follows the latch one cycle later
    a_r4_a_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (A_OUT_REG && a_regce && !a_rst_reg) |=> (a_rdata == $past(a_latch)));
    a_r4_b_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (B_OUT_REG && b_regce && !b_rst_reg) |=> (b_rdata == $past(b_latch)));

    // R6: reset-first acts without enable; enable-first holds without enable
    a_r6_a_rst_first: assert property (@(posedge clk) disable iff (!rst_n)
        (A_OUT_REG && A_RSTREG_FIRST && a_rst_reg) |=> (a_rdata == A_RST_VAL));
    a_r6_b_rst_first: assert property (@(posedge clk) disable iff (!rst_n)
        (B_OUT_REG && B_RSTREG_FIRST && b_rst_reg) |=> (b_rdata == B_RST_VAL));
    a_r6_a_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (A_OUT_REG && !A_RSTREG_FIRST && !a_regce) |=> $stable(a_rdata));
    a_r6_b_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (B_OUT_REG && !B_RSTREG_FIRST && !b_regce) |=> $stable(b_rdata));

    // R7: flag tracks the conflict one cycle later
    a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (CHECKED && conflict) |=> collision);
    a_r7_flag_clr: assert property (@(posedge clk) disable iff (!rst_n)
        !(CHECKED && conflict) |=> !collision);

    // R8: warn mode holds both latches
    a_r8_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (WARN && conflict && !a_rst_latch) |=> $stable(a_latch));
    a_r8_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (WARN && conflict && !b_rst_latch) |=> $stable(b_latch));

    // R9: invalidate mode loads the constants
    a_r9_a_inval: assert property (@(posedge clk) disable iff (!rst_n)
        (INVAL && conflict) |=> (a_latch == A_RST_VAL));
    a_r9_b_inval: assert property (@(posedge clk) disable iff (!rst_n)
        (INVAL && conflict) |=> (b_latch == B_RST_VAL));

endmodule

bind tdp_ram_rso tdp_ram_rso_chk #(
    .ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(LANES*LANE_W),
    .A_RST_VAL(A_RST_VAL), .B_RST_VAL(B_RST_VAL),
    .A_OUT_REG(A_OUT_REG), .B_OUT_REG(B_OUT_REG),
    .A_RSTREG_FIRST(A_RSTREG_FIRST), .B_RSTREG_FIRST(B_RSTREG_FIRST),
    .COLL_MODE(COLL_MODE)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_regce(a_regce),
    .a_rst_latch(a_rst_latch), .a_rst_reg(a_rst_reg), .a_rdata(a_rdata),
    .a_latch(a_latch),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_regce(b_regce),
    .b_rst_latch(b_rst_latch), .b_rst_reg(b_rst_reg), .b_rdata(b_rdata),
    .b_latch(b_latch),
    .collision(collision)
);

// File: tb/tdp_ram_rso_tb_top.sv
// Directed bench for tdp_ram_rso. Two instances share one stimulus:
// dut_i  - A registered reset-first, B bypassed, warn-only collisions
// dut2_i - A registered enable-first, B registered enable-first, invalidate
module tdp_ram_rso_tb_top;

    localparam logic [31:0] ARST = 32'hDEAD_BEEF;
    localparam logic [31:0] BRST = 32'h0BAD_F00D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_en = 0, a_regce = 1, a_rst_latch = 0, a_rst_reg = 0;
    logic b_en = 0, b_regce = 1, b_rst_latch = 0, b_rst_reg = 0;
    logic [3:0]  a_we = '0, b_we = '0;
    logic [5:0]  a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] d1_a, d1_b, d2_a, d2_b;
    logic        d1_c, d2_c;

    logic [31:0] ref_mem [64];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tdp_ram_rso #(.A_RST_VAL(ARST), .B_RST_VAL(BRST)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_regce(a_regce), .a_rst_latch(a_rst_latch), .a_rst_reg(a_rst_reg),
        .a_rdata(d1_a),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_regce(b_regce), .b_rst_latch(b_rst_latch), .b_rst_reg(b_rst_reg),
        .b_rdata(d1_b), .collision(d1_c)
    );

    tdp_ram_rso #(.A_RST_VAL(ARST), .B_RST_VAL(BRST),
                  .A_OUT_REG(1'b1), .A_RSTREG_FIRST(1'b0),
                  .B_OUT_REG(1'b1), .B_RSTREG_FIRST(1'b0),
                  .COLL_MODE(ram_pkg::COLL_ALL)) dut2_i (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_regce(a_regce), .a_rst_latch(a_rst_latch), .a_rst_reg(a_rst_reg),
        .a_rdata(d2_a),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_regce(b_regce), .b_rst_latch(b_rst_latch), .b_rst_reg(b_rst_reg),
        .b_rdata(d2_b), .collision(d2_c)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] we);
        logic [31:0] r = old;
        for (int l = 0; l < 4; l++) if (we[l]) r[l*8 +: 8] = nw[l*8 +: 8];
        return r;
    endfunction

    task automatic idle();
        a_en = 0; a_we = '0; a_rst_latch = 0; a_rst_reg = 0; a_regce = 1;
        b_en = 0; b_we = '0; b_rst_latch = 0; b_rst_reg = 0; b_regce = 1;
    endtask

    task automatic wr_a(input logic [5:0] ad, input logic [3:0] we, input logic [31:0] d);
        a_en = 1; a_we = we; a_addr = ad; a_wdata = d;
        tick(); idle();
        ref_mem[ad] = merge(ref_mem[ad], d, we);
    endtask

    task automatic wr_b(input logic [5:0] ad, input logic [3:0] we, input logic [31:0] d);
        b_en = 1; b_we = we; b_addr = ad; b_wdata = d;
        tick(); idle();
        ref_mem[ad] = merge(ref_mem[ad], d, we);
    endtask

    // Read through A (registered in both instances): data after two edges.
    task automatic rd_a(input logic [5:0] ad, input string req);
        a_en = 1; a_addr = ad;
        tick(); idle(); tick();
        chk(req, d1_a, ref_mem[ad]);
        chk(req, d2_a, ref_mem[ad]);
    endtask

    // Read through B: bypassed in dut_i, registered in dut2_i.
    task automatic rd_b(input logic [5:0] ad, input string req);
        b_en = 1; b_addr = ad;
        tick(); idle();
        chk(req, d1_b, ref_mem[ad]);
        tick();
        chk(req, d2_b, ref_mem[ad]);
    endtask

    task automatic t_reset();
        rst_n = 0; idle(); tick(); tick();
        chk("R10 a reset", d1_a, ARST);
        chk("R10 a reset", d2_a, ARST);
        chk("R10 b reset", d1_b, BRST);
        chk("R10 b reset", d2_b, BRST);
        chk("R10 flag", {31'd0, d1_c}, 32'd0);
        chk("R10 flag", {31'd0, d2_c}, 32'd0);
        rst_n = 1; tick();
    endtask

    task automatic t_lanes();
        wr_a(6'd3, 4'hF, 32'h1122_3344);
        wr_a(6'd3, 4'h5, 32'hAABB_CCDD);
        rd_b(6'd3, "R1 lanes 0,2 from A");
        wr_b(6'd7, 4'hF, 32'h0);
        wr_b(6'd7, 4'hA, 32'hCAFE_BABE);
        rd_a(6'd7, "R1 lanes 1,3 from B");
        wr_a(6'd3, 4'h0, 32'hFFFF_FFFF);
        rd_b(6'd3, "R1 no lane enabled");
    endtask

    task automatic t_read_first();
        logic [31:0] old;
        wr_a(6'd9, 4'hF, 32'h0101_0101);
        old = ref_mem[9];
        a_en = 1; a_we = 4'hF; a_addr = 6'd9; a_wdata = 32'h0202_0202;
        tick(); idle(); tick();
        ref_mem[9] = 32'h0202_0202;
        chk("R2 read-first old data", d1_a, old);
        chk("R2 read-first old data", d2_a, old);
        rd_a(6'd9, "R2 new data after write");
    endtask

    task automatic t_latency();
        rd_a(6'd3, "R4 setup");
        a_en = 1; a_addr = 6'd7;
        tick(); idle();
        chk("R4 registered port one cycle behind", d1_a, ref_mem[3]);
        tick();
        chk("R4 registered port data", d1_a, ref_mem[7]);
    endtask

    task automatic t_latch_rst();
        rd_a(6'd3, "R3 setup");
        a_en = 1; a_rst_latch = 1;
        tick(); idle();
        chk("R3 latch reset not yet at registered output", d1_a, ref_mem[3]);
        tick();
        chk("R3 latch reset via register", d1_a, ARST);
        chk("R3 latch reset via register", d2_a, ARST);
        rd_b(6'd3, "R3 setup b");
        b_en = 1; b_rst_latch = 1;
        tick(); idle();
        chk("R3 latch reset bypassed port", d1_b, BRST);
        tick();
        chk("R3 latch reset registered b", d2_b, BRST);
        rd_b(6'd3, "R3 setup b");
        b_rst_latch = 1;
        tick(); tick(); idle(); tick();
        chk("R3 latch reset ignored while disabled", d1_b, ref_mem[3]);
        chk("R3 latch reset ignored while disabled", d2_b, ref_mem[3]);
    endtask

    task automatic t_reg_rst();
        rd_a(6'd3, "R6 setup");
        a_regce = 0; a_rst_reg = 1;
        tick();
        chk("R6 reset-first acts without enable", d1_a, ARST);
        chk("R6 enable-first holds without enable", d2_a, ref_mem[3]);
        a_regce = 1;
        tick(); idle();
        chk("R6 enable-first resets with enable", d2_a, ARST);
        a_en = 1; a_addr = 6'd7; a_regce = 0;
        tick(); a_en = 0; tick();
        chk("R6 register holds without enable", d1_a, ARST);
        chk("R6 register holds without enable", d2_a, ARST);
        a_regce = 1;
        tick(); idle();
        chk("R6 register loads latch", d1_a, ref_mem[7]);
        chk("R6 register loads latch", d2_a, ref_mem[7]);
        rd_b(6'd3, "R5 setup");
        b_rst_reg = 1;
        tick(); idle();
        chk("R5 register reset no effect when bypassed", d1_b, ref_mem[3]);
        chk("R5 register reset on registered port", d2_b, BRST);
    endtask

    task automatic t_collision();
        rd_b(6'd3, "R7 setup");
        rd_a(6'd7, "R7 setup");
        a_en = 1; a_we = 4'hF; a_addr = 6'd3; a_wdata = 32'hFFFF_0000;
        b_en = 1; b_addr = 6'd3;
        tick(); idle();
        chk("R7 flag on A-write collision", {31'd0, d1_c}, 32'd1);
        chk("R7 flag on A-write collision", {31'd0, d2_c}, 32'd1);
        chk("R8 warn latch b holds", d1_b, ref_mem[3]);
        tick();
        chk("R7 flag lasts one cycle", {31'd0, d1_c}, 32'd0);
        chk("R7 flag lasts one cycle", {31'd0, d2_c}, 32'd0);
        chk("R8 warn latch a holds", d1_a, ref_mem[7]);
        chk("R9 invalidate latch a", d2_a, ARST);
        chk("R9 invalidate latch b", d2_b, BRST);
        rd_b(6'd3, "R8 R9 write blocked");
        b_en = 1; b_we = 4'hF; b_addr = 6'd7; b_wdata = 32'h1234_5678;
        a_en = 1; a_addr = 6'd7;
        tick(); idle();
        chk("R7 flag on B-write collision", {31'd0, d1_c}, 32'd1);
        chk("R7 flag on B-write collision", {31'd0, d2_c}, 32'd1);
        tick();
        rd_a(6'd7, "R8 R9 B write blocked");
        a_en = 1; a_addr = 6'd3; b_en = 1; b_addr = 6'd3;
        tick(); idle();
        chk("R7 no flag on shared read", {31'd0, d1_c}, 32'd0);
        chk("R7 no flag on shared read", {31'd0, d2_c}, 32'd0);
        chk("R7 shared read data", d1_b, ref_mem[3]);
        a_en = 1; a_we = 4'hF; a_addr = 6'd10; a_wdata = 32'hA0A0_A0A0;
        b_en = 1; b_we = 4'hF; b_addr = 6'd11; b_wdata = 32'hB0B0_B0B0;
        tick(); idle();
        ref_mem[10] = 32'hA0A0_A0A0;
        ref_mem[11] = 32'hB0B0_B0B0;
        chk("R7 no flag on distinct addresses", {31'd0, d1_c}, 32'd0);
        rd_a(6'd10, "R1 simultaneous write A");
        rd_b(6'd11, "R1 simultaneous write B");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        t_reset();
        t_lanes();
        t_read_first();
        t_latency();
        t_latch_rst();
        t_reg_rst();
        t_collision();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule